// File: doc/BRIEF.md
# Channel Parameter Packet Receiver

This block takes per-channel parameter records from a host, one byte at a time, over a byte-wide parallel link. Four bytes make one 32-bit record. Each record is split into a satellite number, an amplitude, a pair of phase-rollover flags and a phase value. One record is taken for each of the four channels in a frame. While a frame is in flight, the records go into a hidden shadow bank. Once the sixteenth byte of a frame is in, the whole shadow bank moves into the active bank in one step, and a single-cycle update strobe marks the change. The signal synthesizer downstream reads only the active bank. It therefore never sees a mix of old and new channels.

The host marks the start of every frame with a pulse on the frame-start input. At 2 kHz with four channels of four bytes each, the link has to carry at least 32 k bytes per second. The rollover flags travel with the phase, so the consumer can handle a phase wrap between two updates.

Control is a three-state machine. `ST_IDLE` waits for a frame-start and ignores bytes. `ST_COLLECT` counts and stores bytes. `ST_COMMIT` lasts one cycle and moves shadow to active. The transitions are:
- idle-to-collect on frame-start.
- collect-to-collect on every byte except the last one of the frame. A new frame-start also stays in collect and restarts the counters.
- collect-to-commit on the sixteenth accepted byte.
- commit-to-idle when no frame-start is present.
- commit-to-collect when a frame-start arrives in the commit cycle.

Top module: `chan_param_rx`

## Requirements
- R1: While reset is held and just after it, every active-bank output is zero and `update_o` is low.
- R2: Bytes are most-significant first. The first byte of a record is record bits 31:24 and the fourth is bits 7:0. The satellite number is bits 31:27, the amplitude bits 26:20, the rollover flags bits 19:18 and the phase bits 17:0.
- R3: The records of a frame belong to channels 0, 1, 2 and 3 in order of arrival. Channel c is driven on slice c of each output bus, for example `sv_id_o[c*5 +: 5]`.
- R4: `update_o` is high for exactly one cycle. That cycle is the second clock edge after the edge that takes the sixteenth byte of a frame.
- R5: The active-bank outputs change only in a cycle where `update_o` is high. All four channels change together.
- R6: A frame cut short by a new frame-start produces no strobe and leaves the active bank unchanged. The new frame replaces it entirely.
- R7: Bytes with `byte_valid_i` high are ignored in two cases: before the first frame-start after reset, and after a frame's sixteenth byte until the next frame-start.
- R8: Cycles with `byte_valid_i` low do not advance the byte or channel position, so gaps between bytes are allowed.
- R9: A byte presented in the same cycle as `frame_start_i` is taken as byte 0 of channel 0 of the new frame. A frame-start pulse without a byte only rewinds the position.
- R10: Back-to-back frames are each committed. This holds even when the next frame-start and byte arrive in the commit cycle.
- R11: All field values, including all-zero and all-one, go through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Rewinds to byte 0 of channel 0 |
| byte_valid_i | input | 1 | `byte_i` carries a byte this cycle |
| byte_i | input | 8 | Link data byte |
| sv_id_o | output | 20 | Satellite number, 5 bits per channel |
| amp_o | output | 28 | Amplitude, 7 bits per channel |
| wrap_o | output | 8 | Phase-rollover flags, 2 bits per channel |
| phase_o | output | 72 | Phase, 18 bits per channel |
| update_o | output | 1 | One-cycle pulse: active bank just reloaded |

## Verification
The embedded properties assume three things about the inputs: `frame_start_i` and `byte_valid_i` are clean single-cycle-sampled levels, a frame-start may come at any point, and a byte counts only when `byte_valid_i` is high. They assume no ordering between the two inputs beyond that. The stimulus drives both inputs only between clock edges and releases them after one cycle. It mixes the following patterns: gapless frames, frames with idle gaps, frame-starts with and without a byte, frames that are cut short, stray bytes outside a frame, and a frame that starts in the commit cycle. Every expected record set comes from the R2 bit layout applied to the words the driver sent.

// File: rtl/chrx_pkg.sv
package chrx_pkg;
    localparam int SV_W     = 5;
    localparam int AMP_W    = 7;
    localparam int WRAP_W   = 2;
    localparam int PH_W     = 18;
    localparam int REC_W    = SV_W + AMP_W + WRAP_W + PH_W;
    localparam int BYTE_W   = 8;
    localparam int REC_BYTES = REC_W / BYTE_W;

    // Field order matches the wire layout: satellite number in the top bits.
    typedef struct packed {
        logic [SV_W-1:0]   sv;
        logic [AMP_W-1:0]  amp;
        logic [WRAP_W-1:0] wrap;
        logic [PH_W-1:0]   phase;
    } chan_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2
    } rx_state_t;

    function automatic chan_rec_t split_record(input logic [REC_W-1:0] w);
        chan_rec_t r;
        r.sv    = w[REC_W-1 -: SV_W];
        r.amp   = w[REC_W-SV_W-1 -: AMP_W];
        r.wrap  = w[PH_W+WRAP_W-1 -: WRAP_W];
        r.phase = w[PH_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/chrx_ctrl.sv
module chrx_ctrl
    import chrx_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_BYTES = 4,
    localparam int BW = $clog2(NUM_BYTES),
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          byte_valid,
    output logic          accept,
    output logic [BW-1:0] byte_pos,
    output logic [CW-1:0] ch_sel,
    output logic          rec_done,
    output logic          commit
);
    rx_state_t     state, state_n;
    logic [BW-1:0] byte_cnt, byte_n;
    logic [CW-1:0] ch_cnt, ch_n;
    logic          last_byte, last_ch, frame_done;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_cnt <= '0;
            ch_cnt   <= '0;
        end else begin
            state    <= state_n;
            byte_cnt <= byte_n;
            ch_cnt   <= ch_n;
        end
    end

    // Next-state and output process
    always_comb begin
        accept     = byte_valid && (frame_start || state == ST_COLLECT);
        byte_pos   = frame_start ? '0 : byte_cnt;
        ch_sel     = frame_start ? '0 : ch_cnt;
        last_byte  = (byte_pos == BW'(NUM_BYTES - 1));
        last_ch    = (ch_sel == CW'(NUM_CH - 1));
        rec_done   = accept && last_byte;
        frame_done = rec_done && last_ch;
        commit     = (state == ST_COMMIT);

        state_n = state;
        unique case (state)
            ST_IDLE:    state_n = frame_start ? ST_COLLECT : ST_IDLE;
            ST_COLLECT: state_n = ST_COLLECT;
            ST_COMMIT:  state_n = frame_start ? ST_COLLECT : ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
        if (frame_done)
            state_n = ST_COMMIT;

        byte_n = byte_cnt;
        ch_n   = ch_cnt;
        if (accept) begin
            if (last_byte) begin
                byte_n = '0;
                ch_n   = last_ch ? '0 : ch_sel + 1'b1;
            end else begin
                byte_n = byte_pos + 1'b1;
                ch_n   = ch_sel;
            end
        end else if (frame_start) begin
            byte_n = '0;
            ch_n   = '0;
        end
    end

    // R4: the commit state is only ever entered straight after a record closed
    p_commit_after_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> $past(rec_done));

    // R7: outside a frame the position counters rest at zero
    p_idle_counters_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (byte_cnt == '0 && ch_cnt == '0));
endmodule

// File: rtl/chrx_asm.sv
module chrx_asm
    import chrx_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    parameter int B_W       = 8,
    localparam int BW     = $clog2(NUM_BYTES),
    localparam int HOLD_W = B_W * (NUM_BYTES - 1),
    localparam int WORD_W = B_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BW-1:0]     byte_pos,
    input  logic [B_W-1:0]    byte_in,
    output logic [WORD_W-1:0] word
);
    logic [HOLD_W-1:0] hold;

    // Earlier bytes shift upward; byte 0 of a record restarts the holder.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold <= '0;
        else if (accept) begin
            if (byte_pos == '0)
                hold <= HOLD_W'(byte_in);
            else
                hold <= HOLD_W'({hold, byte_in});
        end
    end

    assign word = {hold, byte_in};
endmodule

// File: rtl/chrx_bank.sv
module chrx_bank
    import chrx_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CW-1:0]                wr_sel,
    input  logic [REC_W-1:0]             wr_word,
    input  logic                         commit,
    output chan_rec_t [NUM_CH-1:0]       active_o,
    output logic                         update_o
);
    chan_rec_t [NUM_CH-1:0] shadow;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[c]   <= '0;
                active_o[c] <= '0;
            end else begin
                if (wr_en && wr_sel == CW'(c))
                    shadow[c] <= split_record(wr_word);
                if (commit)
                    active_o[c] <= shadow[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            update_o <= 1'b0;
        else
            update_o <= commit;
    end

    // R5: the visible bank only moves together with the strobe
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable(active_o));

    // R4: the strobe never stretches beyond one cycle
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);
endmodule

// File: rtl/chan_param_rx.sv
module chan_param_rx
    import chrx_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CW = $clog2(NUM_CH),
    localparam int BW = $clog2(REC_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start_i,
    input  logic                     byte_valid_i,
    input  logic [BYTE_W-1:0]        byte_i,
    output logic [NUM_CH*SV_W-1:0]   sv_id_o,
    output logic [NUM_CH*AMP_W-1:0]  amp_o,
    output logic [NUM_CH*WRAP_W-1:0] wrap_o,
    output logic [NUM_CH*PH_W-1:0]   phase_o,
    output logic                     update_o
);
    logic                   accept, rec_done, commit;
    logic [BW-1:0]          byte_pos;
    logic [CW-1:0]          ch_sel;
    logic [REC_W-1:0]       word;
    chan_rec_t [NUM_CH-1:0] active;

    chrx_ctrl #(.NUM_CH(NUM_CH), .NUM_BYTES(REC_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start_i),
        .byte_valid (byte_valid_i),
        .accept     (accept),
        .byte_pos   (byte_pos),
        .ch_sel     (ch_sel),
        .rec_done   (rec_done),
        .commit     (commit)
    );

    chrx_asm #(.NUM_BYTES(REC_BYTES), .B_W(BYTE_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .byte_pos(byte_pos),
        .byte_in (byte_i),
        .word    (word)
    );

    chrx_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec_done),
        .wr_sel  (ch_sel),
        .wr_word (word),
        .commit  (commit),
        .active_o(active),
        .update_o(update_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign sv_id_o[c*SV_W +: SV_W]     = active[c].sv;
        assign amp_o[c*AMP_W +: AMP_W]     = active[c].amp;
        assign wrap_o[c*WRAP_W +: WRAP_W]  = active[c].wrap;
        assign phase_o[c*PH_W +: PH_W]     = active[c].phase;
    end
endmodule

// File: tb/tb_chan_param_rx.sv
module tb_chan_param_rx;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start_i = 1'b0;
    logic              byte_valid_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic [NCH*5-1:0]  sv_id_o;
    logic [NCH*7-1:0]  amp_o;
    logic [NCH*2-1:0]  wrap_o;
    logic [NCH*18-1:0] phase_o;
    logic              update_o;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    int pushed = 0;
    bit done = 0;
    bit prev_upd = 0;
    logic [127:0] exp_q[$];
    logic [127:0] last_commit = '0;

    always #10 clk = ~clk;

    chan_param_rx dut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .sv_id_o(sv_id_o),
        .amp_o(amp_o), .wrap_o(wrap_o), .phase_o(phase_o), .update_o(update_o)
    );

    // Rebuild the four words from the output slices using the R2/R3 layout.
    function automatic logic [127:0] seen_bank();
        logic [127:0] v;
        for (int c = 0; c < NCH; c++)
            v[c*32 +: 32] = {sv_id_o[c*5 +: 5], amp_o[c*7 +: 7],
                             wrap_o[c*2 +: 2], phase_o[c*18 +: 18]};
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (update_o) begin
                check(!prev_upd, "R4 strobe wider than one cycle", 128'(prev_upd), 128'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 R7 strobe with no complete frame", 128'd1, 128'd0);
                end else begin
                    logic [127:0] f;
                    f = exp_q.pop_front();
                    check(seen_bank() == f, "R2 R3 R11 decoded bank", seen_bank(), f);
                    last_commit = f;
                end
                strobes++;
            end
            prev_upd = update_o;
        end
    end

    task automatic put_byte(input logic [7:0] b, input bit fs);
        byte_i        = b;
        byte_valid_i  = 1'b1;
        frame_start_i = fs;
        @(negedge clk);
        byte_valid_i  = 1'b0;
        frame_start_i = 1'b0;
    endtask

    // Driver: sends nbytes of frame f; a full frame goes into the scoreboard.
    task automatic send_frame(input logic [127:0] f, input bit fs_with_byte,
                              input int gap, input int nbytes);
        if (!fs_with_byte) begin
            frame_start_i = 1'b1;
            @(negedge clk);
            frame_start_i = 1'b0;
        end
        for (int i = 0; i < nbytes; i++) begin
            int c;
            int b;
            c = i / 4;
            b = i % 4;
            if (i == 15) begin
                exp_q.push_back(f);
                pushed++;
            end
            put_byte(f[c*32 + 24 - 8*b +: 8], fs_with_byte && i == 0);
            repeat (gap) @(negedge clk);
        end
    endtask

    function automatic logic [127:0] rand_frame();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(seen_bank() == '0, "R1 bank zero in reset", seen_bank(), '0);
        check(update_o == 1'b0, "R1 strobe low in reset", 128'(update_o), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(seen_bank() == '0, "R1 bank zero after reset", seen_bank(), '0);

        // R7: bytes before any frame-start are ignored
        for (int i = 0; i < 20; i++) put_byte(8'(i * 13 + 1), 1'b0);
        repeat (4) @(negedge clk);
        check(strobes == 0, "R7 no strobe before frame-start", 128'(strobes), 128'd0);
        check(seen_bank() == '0, "R7 bank untouched before frame-start", seen_bank(), '0);

        // R2 R3: distinct per-channel words, separate frame-start pulse
        send_frame({32'h4321_8765, 32'h0BAD_F00D, 32'hC0FF_EE12, 32'h1234_5678}, 1'b0, 0, 16);
        repeat (4) @(negedge clk);
        // R11: boundary values
        send_frame({128{1'b1}}, 1'b0, 0, 16);
        repeat (3) @(negedge clk);
        send_frame('0, 1'b0, 0, 16);
        repeat (3) @(negedge clk);
        send_frame({4{32'hAAAA_5555}}, 1'b0, 0, 16);
        repeat (3) @(negedge clk);
        // R8: gaps between bytes
        send_frame(rand_frame(), 1'b0, 3, 16);
        repeat (3) @(negedge clk);
        // R9: frame-start carries the first byte
        send_frame(rand_frame(), 1'b1, 0, 16);
        repeat (3) @(negedge clk);

        // R6: truncated frame, then a full one replaces it
        send_frame(rand_frame(), 1'b1, 1, 9);
        repeat (6) @(negedge clk);
        check(seen_bank() == last_commit, "R6 bank held after truncated frame", seen_bank(), last_commit);
        check(exp_q.size() == 0 && strobes == pushed, "R6 no strobe for truncated frame",
              128'(strobes), 128'(pushed));
        send_frame(rand_frame(), 1'b1, 0, 16);
        repeat (3) @(negedge clk);

        // R7: trailing bytes after a complete frame are ignored
        for (int i = 0; i < 16; i++) put_byte(8'(255 - i * 7), 1'b0);
        repeat (4) @(negedge clk);
        check(seen_bank() == last_commit, "R7 bank held after trailing bytes", seen_bank(), last_commit);
        check(strobes == pushed, "R7 no strobe from trailing bytes", 128'(strobes), 128'(pushed));

        // R10: back-to-back frames, next one starts in the commit cycle
        send_frame(rand_frame(), 1'b1, 0, 16);
        send_frame(rand_frame(), 1'b1, 0, 16);
        send_frame(rand_frame(), 1'b1, 0, 16);
        repeat (4) @(negedge clk);

        for (int k = 0; k < 6; k++) begin
            send_frame(rand_frame(), k % 2 == 0, k % 3, 16);
            repeat (2) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10 every frame committed", 128'(exp_q.size()), 128'd0);
        check(strobes == pushed, "R10 strobe count", 128'(strobes), 128'(pushed));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule